// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte-wide meeting point between a host bus and the small controller CPU that runs a PC-style keyboard controller. The host side can load one byte into an input buffer, and it can read one byte from an output buffer or read a status byte. The CPU side does the reverse: it drains the input buffer, fills the output buffer, keeps a few status bits of its own, and controls whether a full input buffer interrupts it.

Two flags in the status byte track the buffers. A write from one side sets a flag, and a read from the other side clears it. Each host write is also tagged as a command or as data by one host address bit, and the tag stays in the status byte for the CPU to inspect. Every access is a one-cycle strobe in a single clock domain. Read data is combinational from the registers, and a read changes a flag only in the cycle its strobe is high.

Host address bit (`hostAddrTag`): 0 selects the output data byte for reads and a data write for writes. 1 selects the status byte for reads and a command write for writes. CPU register select (`cpuAddr`): 0 is the data registers (read the input byte, write the output byte), 1 is the status byte, 2 is the control byte with the interrupt enable in bit 0, and 3 reads as zero and ignores writes.

Top module: `kbd_mailbox`

## Requirements
- R1: After reset the status byte reads 00h from both sides, the control byte reads 00h, and `cpuIrq` is low.
- R2: A host write stores `hostWdata` as the input byte and sets the input-full flag (status bit 1). The CPU reads that byte back at register 0.
- R3: Every host write loads the command tag (status bit 3) from `hostAddrTag`: 1 means command and 0 means data. The tag holds its value until the next host write.
- R4: A CPU read strobe at register 0 clears the input-full flag. CPU reads of the status or control byte leave it unchanged.
- R5: A CPU write at register 0 stores the output byte and sets the output-full flag (status bit 0). The host reads that byte with `hostAddrTag` = 0.
- R6: A host read strobe with `hostAddrTag` = 0 clears the output-full flag. A host status read leaves every status bit unchanged.
- R7: `cpuIrq` is high exactly when the input-full flag is set and the interrupt enable (control bit 0) is 1. The enable resets to 0.
- R8: A CPU write at register 1 changes only status bits 7, 6, 5, 4 and 2. Bits 0, 1 and 3 of that write have no effect. A host write never changes those user bits.
- R9: If a set event and a clear event hit the same flag in the same cycle, the flag ends up set. The read in that cycle returns the old byte, and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostAddrTag | input | 1 | Host address bit: 0 data / output byte, 1 command / status |
| hostWdata | input | DATA_W | Host write byte |
| hostRdata | output | DATA_W | Output byte or status byte, per `hostAddrTag` |
| cpuWr | input | 1 | CPU write strobe, one cycle |
| cpuRd | input | 1 | CPU read strobe, one cycle |
| cpuAddr | input | 2 | CPU register select |
| cpuWdata | input | DATA_W | CPU write byte |
| cpuRdata | output | DATA_W | Selected CPU register |
| cpuIrq | output | 1 | Input-full interrupt toward the CPU |

## Verification
The bench uses the default byte width and the default flag positions (output-full at bit 0, input-full at bit 1, tag at bit 3). With these values, every one of the five user bits and every hardware flag can be told apart in a single status read. A CPU write of FFh or 0Bh to the status byte therefore shows at once whether a flag leaked through. Same-cycle collisions (a host write against a CPU data read, and a CPU output write against a host data read) are driven on purpose to check the set-wins rule. Repeated status and control reads check that reads without a strobe at register 0 have no side effect.

// File: rtl/kbd_mailbox_pkg.sv
`timescale 1ns/1ps
package kbd_mailbox_pkg;
  // Status byte positions that the host and CPU decode
  localparam int OBF_POS = 0;
  localparam int IBF_POS = 1;
  localparam int TAG_POS = 3;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cpu_sel_e;

  typedef struct packed {
    logic inLoad;     // host write into the input byte
    logic cmdTag;     // tag that goes with inLoad
    logic outUnload;  // host read of the output byte
    logic inUnload;   // CPU read of the input byte
    logic outLoad;    // CPU write of the output byte
    logic userLoad;   // CPU write of the status user bits
    logic ctrlLoad;   // CPU write of the control byte
  } mbox_strobe_t;
endpackage

// File: rtl/kbd_mailbox_ctrl.sv
`timescale 1ns/1ps
module kbd_mailbox_ctrl
  import kbd_mailbox_pkg::*;
(
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic         hostAddrTag,
  input  logic         cpuWr,
  input  logic         cpuRd,
  input  logic [1:0]   cpuAddr,
  output mbox_strobe_t stb,
  output cpu_sel_e     cpuSel,
  output logic         hostSelStat
);
  always_comb begin
    cpuSel        = cpu_sel_e'(cpuAddr);
    hostSelStat   = hostAddrTag;
    stb.inLoad    = hostWr;
    stb.cmdTag    = hostAddrTag;
    stb.outUnload = hostRd && !hostAddrTag;
    stb.inUnload  = cpuRd && (cpuSel == SEL_DATA);
    stb.outLoad   = cpuWr && (cpuSel == SEL_DATA);
    stb.userLoad  = cpuWr && (cpuSel == SEL_STAT);
    stb.ctrlLoad  = cpuWr && (cpuSel == SEL_CTRL);
  end
endmodule

// File: rtl/kbd_mailbox_dp.sv
`timescale 1ns/1ps
module kbd_mailbox_dp
  import kbd_mailbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      stb,
  input  cpu_sel_e          cpuSel,
  input  logic              hostSelStat,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] statusVal,
  output logic              irqEn,
  output logic              cpuIrq
);
  logic [DATA_W-1:0] inData;
  logic [DATA_W-1:0] outData;
  logic obfQ, ibfQ, tagQ;

  // Flags: a set event takes priority over a clear event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obfQ  <= 1'b0;
      ibfQ  <= 1'b0;
      tagQ  <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      if (stb.outLoad)        obfQ <= 1'b1;
      else if (stb.outUnload) obfQ <= 1'b0;
      if (stb.inLoad)         ibfQ <= 1'b1;
      else if (stb.inUnload)  ibfQ <= 1'b0;
      if (stb.inLoad)         tagQ <= stb.cmdTag;
      if (stb.ctrlLoad)       irqEn <= cpuWdata[0];
    end
  end

  // Data bytes carry no reset; the flags say whether they are valid
  always_ff @(posedge clk) begin
    if (stb.inLoad)  inData  <= hostWdata;
    if (stb.outLoad) outData <= cpuWdata;
  end

  // Status byte: flags at fixed positions, a user register at every other bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_stat
    if (i == OBF_POS) begin : g_obf
      assign statusVal[i] = obfQ;
    end else if (i == IBF_POS) begin : g_ibf
      assign statusVal[i] = ibfQ;
    end else if (i == TAG_POS) begin : g_tag
      assign statusVal[i] = tagQ;
    end else begin : g_user
      logic userQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             userQ <= 1'b0;
        else if (stb.userLoad) userQ <= cpuWdata[i];
      end
      assign statusVal[i] = userQ;
    end
  end

  always_comb begin
    hostRdata = hostSelStat ? statusVal : outData;
    unique case (cpuSel)
      SEL_DATA: cpuRdata = inData;
      SEL_STAT: cpuRdata = statusVal;
      SEL_CTRL: cpuRdata = {{(DATA_W-1){1'b0}}, irqEn};
      default:  cpuRdata = '0;
    endcase
  end

  assign cpuIrq = ibfQ & irqEn;
endmodule

// File: rtl/kbd_mailbox.sv
`timescale 1ns/1ps
module kbd_mailbox
  import kbd_mailbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostAddrTag,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [1:0]        cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuIrq
);
  mbox_strobe_t      stb;
  cpu_sel_e          cpuSel;
  logic              hostSelStat;
  logic [DATA_W-1:0] statusVal;
  logic              irqEn;

  kbd_mailbox_ctrl u_ctrl (
    .hostWr      (hostWr),
    .hostRd      (hostRd),
    .hostAddrTag (hostAddrTag),
    .cpuWr       (cpuWr),
    .cpuRd       (cpuRd),
    .cpuAddr     (cpuAddr),
    .stb         (stb),
    .cpuSel      (cpuSel),
    .hostSelStat (hostSelStat)
  );

  kbd_mailbox_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cpuSel      (cpuSel),
    .hostSelStat (hostSelStat),
    .hostWdata   (hostWdata),
    .cpuWdata    (cpuWdata),
    .hostRdata   (hostRdata),
    .cpuRdata    (cpuRdata),
    .statusVal   (statusVal),
    .irqEn       (irqEn),
    .cpuIrq      (cpuIrq)
  );
endmodule

// File: rtl/kbd_mailbox_chk.sv
`timescale 1ns/1ps
module kbd_mailbox_chk
  import kbd_mailbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic              hostRd,
  input logic              hostAddrTag,
  input logic              cpuWr,
  input logic              cpuRd,
  input logic [1:0]        cpuAddr,
  input logic [DATA_W-1:0] statusVal,
  input logic              irqEn,
  input logic              cpuIrq
);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    DATA_W'((1 << OBF_POS) | (1 << IBF_POS) | (1 << TAG_POS));
  localparam logic [DATA_W-1:0] USER_MASK = ~FLAG_MASK;

  p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> statusVal[IBF_POS]);

  p_tag_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> statusVal[TAG_POS] == $past(hostAddrTag));

  p_ibf_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuAddr == 2'd0 && !hostWr) |=> !statusVal[IBF_POS]);

  p_obf_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == 2'd0) |=> statusVal[OBF_POS]);

  p_obf_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostAddrTag && !(cpuWr && cpuAddr == 2'd0)) |=> !statusVal[OBF_POS]);

  p_irq_needs_ibf_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (statusVal[IBF_POS] && irqEn));

  p_irq_rise_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuIrq) |-> ($past(hostWr) || $past(cpuWr && cpuAddr == 2'd2)));

  p_user_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWr && cpuAddr == 2'd1) |=> $stable(statusVal & USER_MASK));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == 2'd0 && hostRd && !hostAddrTag) |=> statusVal[OBF_POS]);
endmodule

bind kbd_mailbox kbd_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostWr      (hostWr),
  .hostRd      (hostRd),
  .hostAddrTag (hostAddrTag),
  .cpuWr       (cpuWr),
  .cpuRd       (cpuRd),
  .cpuAddr     (cpuAddr),
  .statusVal   (statusVal),
  .irqEn       (irqEn),
  .cpuIrq      (cpuIrq)
);

// File: tb/kbd_mailbox_tb.sv
`timescale 1ns/1ps
module kbd_mailbox_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0, hostRd = 1'b0, hostAddrTag = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       cpuWr = 1'b0, cpuRd = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0;
  logic [7:0] cpuRdata;
  logic       cpuIrq;
  logic       probeIrq = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  kbd_mailbox #(.DATA_W(8)) u_dut (
    .clk(clk), .rstN(rstN),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddrTag(hostAddrTag),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuIrq(cpuIrq)
  );

  // Scoreboard item: kind 0 host read, 1 CPU read, 2 interrupt probe
  typedef struct {
    int         kind;
    logic [7:0] val;
    string      req;
  } exp_t;
  exp_t sb[$];

  // Reference model built from the requirements
  logic       mObf = 0, mIbf = 0, mTag = 0, mIen = 0;
  logic [7:0] mUser = 0, mIn = 0, mOut = 0;

  function automatic logic [7:0] mStat();
    return mUser | {4'b0, mTag, 1'b0, mIbf, mObf};
  endfunction

  task automatic pushExp(input int kind, input logic [7:0] val, input string req);
    exp_t e;
    e.kind = kind;
    e.val  = val;
    e.req  = req;
    sb.push_back(e);
  endtask

  task automatic access(input logic hw, input logic hr, input logic ht, input logic [7:0] hd,
                        input logic cw, input logic cr, input logic [1:0] ca, input logic [7:0] cd,
                        input logic pi, input string req);
    if (hr) pushExp(0, ht ? mStat() : mOut, req);
    if (cr) begin
      case (ca)
        2'd0: pushExp(1, mIn, req);
        2'd1: pushExp(1, mStat(), req);
        2'd2: pushExp(1, {7'b0, mIen}, req);
        default: pushExp(1, 8'h00, req);
      endcase
    end
    if (pi) pushExp(2, {7'b0, mIbf & mIen}, req);
    hostWr = hw; hostRd = hr; hostAddrTag = ht; hostWdata = hd;
    cpuWr = cw; cpuRd = cr; cpuAddr = ca; cpuWdata = cd; probeIrq = pi;
    @(posedge clk);
    #0.5;
    hostWr = 0; hostRd = 0; cpuWr = 0; cpuRd = 0; probeIrq = 0;
    // clears first, then sets, so a set wins
    if (hr && !ht)        mObf = 0;
    if (cr && ca == 2'd0) mIbf = 0;
    if (hw) begin mIbf = 1; mIn = hd; mTag = ht; end
    if (cw) begin
      case (ca)
        2'd0: begin mOut = cd; mObf = 1; end
        2'd1: mUser = cd & 8'hF4;
        2'd2: mIen = cd[0];
        default: ;
      endcase
    end
  endtask

  task automatic hostWrite(input logic t, input logic [7:0] d);
    access(1, 0, t, d, 0, 0, 2'd0, 8'h00, 0, "");
  endtask
  task automatic hostRead(input logic t, input string req);
    access(0, 1, t, 8'h00, 0, 0, 2'd0, 8'h00, 0, req);
  endtask
  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d);
    access(0, 0, 0, 8'h00, 1, 0, a, d, 0, "");
  endtask
  task automatic cpuRead(input logic [1:0] a, input string req);
    access(0, 0, 0, 8'h00, 0, 1, a, 8'h00, 0, req);
  endtask
  task automatic irqCheck(input string req);
    access(0, 0, 0, 8'h00, 0, 0, 2'd0, 8'h00, 1, req);
  endtask

  task automatic compare(input int kind, input logic [7:0] act);
    exp_t e;
    checks++;
    if (sb.size() == 0) begin
      fails++;
      $display("FAIL scoreboard empty: act=%h exp=none", act);
      return;
    end
    e = sb.pop_front();
    if (e.kind != kind || e.val !== act) begin
      fails++;
      $display("FAIL %s kind=%0d act=%h exp=%h", e.req, kind, act, e.val);
    end
  endtask

  // Monitor: outputs are sampled on the falling edge, during the strobe cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (hostRd)   compare(0, hostRdata);
      if (cpuRd)    compare(1, cpuRdata);
      if (probeIrq) compare(2, {7'b0, cpuIrq});
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #0.5 rstN = 1'b1;
    @(posedge clk); #0.5;

    // R1 reset state
    hostRead(1, "R1");
    cpuRead(1, "R1");
    cpuRead(2, "R1");
    irqCheck("R1");

    // R5 output byte and flag, R6 clear on host data read only
    cpuWrite(0, 8'hA5);
    hostRead(1, "R5");
    hostRead(1, "R6");
    hostRead(0, "R5");
    hostRead(1, "R6");

    // R2 data write, R3 tag, R4 clear on CPU data read only
    hostWrite(0, 8'h3C);
    hostRead(1, "R2");
    cpuRead(1, "R4");
    cpuRead(2, "R4");
    hostRead(1, "R4");
    cpuRead(0, "R2");
    hostRead(1, "R4");
    hostWrite(1, 8'hD4);
    cpuRead(1, "R3");
    cpuRead(0, "R3");
    hostRead(1, "R3");
    cpuWrite(0, 8'h5A);
    hostRead(1, "R3");
    hostRead(0, "R5");

    // R7 interrupt gating
    cpuWrite(2, 8'h01);
    cpuRead(2, "R7");
    irqCheck("R7");
    hostWrite(0, 8'h11);
    irqCheck("R7");
    cpuRead(1, "R7");
    irqCheck("R7");
    cpuRead(0, "R7");
    irqCheck("R7");
    cpuWrite(2, 8'hFE);
    hostWrite(0, 8'h22);
    irqCheck("R7");
    cpuWrite(2, 8'h01);
    irqCheck("R7");
    cpuRead(0, "R7");
    irqCheck("R7");
    cpuWrite(2, 8'h00);

    // R8 user bits
    cpuWrite(1, 8'hFF);
    hostRead(1, "R8");
    hostWrite(1, 8'h00);
    hostRead(1, "R8");
    cpuRead(0, "R8");
    cpuWrite(1, 8'h0B);
    hostRead(1, "R8");
    cpuWrite(1, 8'hA4);
    cpuRead(1, "R8");

    // R9 same-cycle set and clear
    hostWrite(0, 8'h77);
    access(1, 0, 1, 8'h88, 0, 1, 2'd0, 8'h00, 0, "R9");
    hostRead(1, "R9");
    cpuRead(0, "R9");
    hostRead(1, "R9");
    cpuWrite(0, 8'h66);
    access(0, 1, 0, 8'h00, 1, 0, 2'd0, 8'h99, 0, "R9");
    hostRead(1, "R9");
    hostRead(0, "R9");
    hostRead(1, "R9");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard leftover act=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule